// File: doc/BRIEF.md
# Parallel Bus Slave Read Responder

This block answers read accesses that an external master issues on a synchronous parallel expansion bus. The master selects the target with an active-low chip select, presents a word address and pulls the active-low read strobe. The responder then asks an internal synchronous memory port for the word and pulls its active-low wait line until the word comes back. It then drives the word with one even-parity bit per byte lane for as long as the master keeps the access open.

Three access shapes are served: a single-word read, several single-word reads back to back while the chip select stays low, and an incrementing burst of up to eight words. In a burst the responder fetches the following words ahead of need. After wait is released the master steps the address by one each time it wants the next word, and it may hold any word for as long as it likes. The master can end the access in any cycle by releasing chip select or the read strobe. Writes on the bus are not served.

Top module: `xbus_read_target`

## Requirements
- R1: While `rst` is high and on the cycle after it, `wait_n` is 1, `data_oe` is 0 and no access is in progress; a reset in the middle of an access abandons it.
- R2: A read starts in the cycle where `cs_n`=0, `rd_n`=0 and `wr_n`=1 are sampled and `rd_n` was 1 at the previous edge. In that same cycle `mem_req` is 1 and `mem_addr` equals `addr`, and from the next cycle `wait_n` is 0.
- R3: `wait_n` stays 0 for exactly `LAT` cycles after the start. It then returns to 1, and in that cycle `data_oe` is 1 and `data_out` carries the word stored at the start address.
- R4: `parity_out[i]` is the XOR of `data_out[8*i+7:8*i]`, so each lane plus its parity bit holds an even count of ones. `be_n` has no effect on data or parity.
- R5: While the master holds the address unchanged in the data phase, `data_out` and `parity_out` stay stable for any number of cycles.
- R6: With `burst`=1 at the start, each address one higher than the previous one, presented after wait is released, yields the word for that address one cycle later. This holds for up to `BMAX` words, and `wait_n` does not fall again.
- R7: When the master raises `cs_n` in any cycle of the data phase, the block is idle from the next cycle: `wait_n`=1, `data_oe`=0 and `mem_req`=0, even when burst fetches were still outstanding.
- R8: With `cs_n` held at 0, raising `rd_n` ends the read, and `data_oe` goes to 0 while `wait_n` stays 1. A following `rd_n`=0 starts a new read: `wait_n` falls on the next cycle and the new word follows after `LAT` cycles.
- R9: `data_oe` is 1 only in the data phase, and only while both `cs_n` and `rd_n` are 0. It drops in the same cycle that either strobe rises.
- R10: A cycle with `cs_n`, `rd_n` and `wr_n` all 0 starts nothing: `mem_req` stays 0, and `wait_n` remains 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Target select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; a read starts only while it is high |
| be_n | input | DW/8 | Byte-lane enables, active low; do not change the returned data |
| burst | input | 1 | Marks an incrementing burst, sampled when a read starts |
| addr | input | AW | Word address from the master |
| wait_n | output | 1 | Wait, active low, held while a word is being fetched |
| data_out | output | DW | Read data toward the bus |
| parity_out | output | DW/8 | Even parity, one bit per byte lane of `data_out` |
| data_oe | output | 1 | Output enable for `data_out` and `parity_out` |
| mem_req | output | 1 | Read request to the internal memory port |
| mem_addr | output | AW | Word address of the request |
| mem_rdata | input | DW | Memory data, valid `LAT` cycles after the request |

## Verification
In a burst with no stretch, the master's address step onto word k happens in the same cycle as the fetched word k arrives from memory. The word must then be forwarded past the buffer rather than read from it. The bench provokes this by stepping the address on the very cycle after wait rises, and it judges each word against a memory model computed in the bench. The second collision is the master ending a burst while prefetches are still in flight. The burst of three out of eight fetched words checks that the block goes quiet on the next cycle, with no request, no enable and wait high.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DATA = 2'd2,
        ST_NOP  = 2'd3
    } xbr_state_e;

    function automatic logic lane_parity(input logic [LANE_W-1:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/xbr_lat_pipe.sv
module xbr_lat_pipe #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic req,
    output logic arrive,
    output logic pending
);

    logic [LAT-1:0] vld;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld <= '0;
        end else begin
            vld[0] <= req;
            for (int k = 1; k < LAT; k++) begin
                vld[k] <= vld[k-1];
            end
        end
    end

    assign arrive  = vld[LAT-1];
    assign pending = |vld;

endmodule

// File: rtl/xbr_fsm.sv
module xbr_fsm
    import xbr_pkg::*;
#(
    parameter int AW   = 16,
    parameter int BMAX = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_n,
    input  logic                     rd_n,
    input  logic                     wr_n,
    input  logic                     burst,
    input  logic [AW-1:0]            addr,
    input  logic                     arrive,
    input  logic                     pending,
    output xbr_state_e               state,
    output logic                     start,
    output logic                     flush,
    output logic                     mem_req,
    output logic [AW-1:0]            mem_addr,
    output logic [$clog2(BMAX)-1:0]  sel
);

    localparam int OFFW = $clog2(BMAX);
    localparam int CNTW = $clog2(BMAX + 1);

    xbr_state_e      nxt;
    logic            rd_prev;
    logic            burst_q;
    logic [AW-1:0]   base;
    logic [CNTW-1:0] issued;
    logic            active;
    logic            more;

    assign active = (state == ST_WAIT) || (state == ST_DATA);
    assign start  = ((state == ST_IDLE) || (state == ST_NOP)) &&
                    !cs_n && !rd_n && wr_n && rd_prev;
    assign more   = active && burst_q && (issued < CNTW'(BMAX));
    assign flush  = active && (cs_n || rd_n);

    assign mem_req  = start || more;
    assign mem_addr = start ? addr : (base + AW'(issued));
    assign sel      = burst_q ? (addr[OFFW-1:0] - base[OFFW-1:0]) : '0;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_WAIT;
            ST_NOP: begin
                if (cs_n)       nxt = ST_IDLE;
                else if (start) nxt = ST_WAIT;
            end
            ST_WAIT, ST_DATA: begin
                if (cs_n)                          nxt = ST_IDLE;
                else if (rd_n)                     nxt = ST_NOP;
                else if (state == ST_WAIT && arrive) nxt = ST_DATA;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            rd_prev <= 1'b1;
            burst_q <= 1'b0;
            base    <= '0;
            issued  <= '0;
        end else begin
            state   <= nxt;
            rd_prev <= rd_n;
            if (start) begin
                base    <= addr;
                burst_q <= burst;
                issued  <= CNTW'(1);
            end else if (more) begin
                issued  <= issued + CNTW'(1);
            end
        end
    end

    // R6: once data flows, wait never returns within the same read
    p_no_rewait_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |=> (state != ST_WAIT));

    // R7: idle means no fetch is left in flight
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !pending);

endmodule

// File: rtl/xbr_word_buf.sv
module xbr_word_buf
    import xbr_pkg::*;
#(
    parameter int DW   = 32,
    parameter int BMAX = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     arrive,
    input  logic                     load,
    input  logic [$clog2(BMAX)-1:0]  sel,
    input  logic [DW-1:0]            rdata,
    output logic [DW-1:0]            data_q,
    output logic [DW/LANE_W-1:0]     par_q
);

    localparam int OFFW  = $clog2(BMAX);
    localparam int LANES = DW / LANE_W;

    logic [DW-1:0]    words [BMAX];
    logic [OFFW-1:0]  fill;
    logic [DW-1:0]    pick;
    logic [LANES-1:0] pick_par;

    assign pick = (arrive && (sel == fill)) ? rdata : words[sel];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign pick_par[i] = lane_parity(pick[i*LANE_W +: LANE_W]);

        // R4: every lane plus its parity bit carries an even count of ones
        p_lane_parity_r4: assert property (@(posedge clk) disable iff (rst)
            par_q[i] == (^data_q[i*LANE_W +: LANE_W]));
    end

    always_ff @(posedge clk) begin
        if (arrive) begin
            words[fill] <= rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill   <= '0;
            data_q <= '0;
            par_q  <= '0;
        end else begin
            if (start) begin
                fill <= '0;
            end else if (arrive) begin
                fill <= fill + OFFW'(1);
            end
            if (load) begin
                data_q <= pick;
                par_q  <= pick_par;
            end
        end
    end

endmodule

// File: rtl/xbus_read_target.sv
module xbus_read_target
    import xbr_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int BMAX = 8,
    parameter int LAT  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            rd_n,
    input  logic            wr_n,
    input  logic [DW/8-1:0] be_n,
    input  logic            burst,
    input  logic [AW-1:0]   addr,
    output logic            wait_n,
    output logic [DW-1:0]   data_out,
    output logic [DW/8-1:0] parity_out,
    output logic            data_oe,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic [DW-1:0]   mem_rdata
);

    localparam int OFFW = $clog2(BMAX);

    xbr_state_e      state;
    logic            start;
    logic            flush;
    logic            arrive;
    logic            pending;
    logic            load;
    logic [OFFW-1:0] sel;
    logic            unused_be;

    assign unused_be = ^be_n;

    xbr_fsm #(.AW(AW), .BMAX(BMAX)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .burst    (burst),
        .addr     (addr),
        .arrive   (arrive),
        .pending  (pending),
        .state    (state),
        .start    (start),
        .flush    (flush),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .sel      (sel)
    );

    xbr_lat_pipe #(.LAT(LAT)) u_lat (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .req     (mem_req),
        .arrive  (arrive),
        .pending (pending)
    );

    assign load = ((state == ST_WAIT) && arrive) || (state == ST_DATA);

    xbr_word_buf #(.DW(DW), .BMAX(BMAX)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .arrive (arrive),
        .load   (load),
        .sel    (sel),
        .rdata  (mem_rdata),
        .data_q (data_out),
        .par_q  (parity_out)
    );

    assign wait_n  = (state != ST_WAIT);
    assign data_oe = (state == ST_DATA) && !cs_n && !rd_n;

    // R2: a recognised start pulls wait on the next cycle
    p_start_waits_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> !wait_n);

    // R3: leaving the wait phase needs the fetched word to have arrived
    p_release_on_arrival_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_WAIT) |-> $past(arrive));

    // R5: unchanged address over two data loads keeps the word on the bus
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_DATA && $past(state, 2) == ST_DATA &&
         $past(addr) == $past(addr, 2)) |-> ($stable(data_out) && $stable(parity_out)));

    // R8: with select held, a fresh strobe out of the gap restarts the wait
    p_restart_from_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_NOP && !cs_n && !rd_n && wr_n) |=> !wait_n);

    // R9: the drivers only switch on after a wait or data cycle
    p_oe_after_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(data_oe) |-> ($past(state) == ST_WAIT || $past(state) == ST_DATA));

endmodule

// File: tb/sim_xbus_read_target.sv
module sim_xbus_read_target;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam int NVEC       = 6;

    // addr[31:16] | words[15:12] | stretch[11:8] | be_n[7:4]
    localparam logic [31:0] VEC [NVEC] = '{
        32'h0010_1000,
        32'h1234_13F0,
        32'h00F8_8000,
        32'h0FFD_4250,
        32'h4000_31A0,
        32'hFFFF_2030
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [3:0]  be_n = 4'h0;
    logic        burst = 1'b0;
    logic [15:0] addr = 16'h0;
    logic        wait_n;
    logic [31:0] data_out;
    logic [3:0]  parity_out;
    logic        data_oe;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [31:0] mem_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] mpipe [LAT];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mword(input logic [15:0] a);
        return {a ^ 16'h5AC3, a + 16'h1F07};
    endfunction

    function automatic logic [3:0] epar(input logic [31:0] d);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = ^d[i*8 +: 8];
        return r;
    endfunction

    always @(posedge clk) begin
        mpipe[0] <= mem_addr;
        for (int k = 1; k < LAT; k++) mpipe[k] <= mpipe[k-1];
    end
    assign mem_rdata = mword(mpipe[LAT-1]);

    xbus_read_target #(.AW(16), .DW(32), .BMAX(8), .LAT(LAT)) u0 (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .be_n       (be_n),
        .burst      (burst),
        .addr       (addr),
        .wait_n     (wait_n),
        .data_out   (data_out),
        .parity_out (parity_out),
        .data_oe    (data_oe),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] a, input int len, input int st,
                           input logic [3:0] be);
        logic [15:0] cur;
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = a; burst = (len > 1); be_n = be;
        #1;
        chk(mem_req === 1'b1, "R2 request at start", 32'(mem_req), 32'd1);
        chk(mem_addr === a, "R2 request address", 32'(mem_addr), 32'(a));
        for (int k = 0; k < LAT; k++) begin
            @(negedge clk);
            chk(wait_n === 1'b0, "R3 wait held for latency", 32'(wait_n), 32'd0);
        end
        @(negedge clk);
        chk(wait_n === 1'b1 && data_oe === 1'b1, "R3 release with enable",
            {30'd0, wait_n, data_oe}, 32'd3);
        for (int w = 0; w < len; w++) begin
            cur = a + 16'(w);
            if (w > 0) begin
                addr = cur;
                @(negedge clk);
                chk(wait_n === 1'b1, "R6 no wait inside burst", 32'(wait_n), 32'd1);
                chk(data_out === mword(cur), "R6 burst word", data_out, mword(cur));
            end else begin
                chk(data_out === mword(cur), "R3 first word", data_out, mword(cur));
            end
            chk(parity_out === epar(mword(cur)), "R4 lane parity",
                32'(parity_out), 32'(epar(mword(cur))));
            for (int s = 0; s < st; s++) begin
                @(negedge clk);
                chk(data_out === mword(cur) && parity_out === epar(mword(cur)),
                    "R5 stretched word", data_out, mword(cur));
            end
        end
        cs_n = 1'b1; rd_n = 1'b1; burst = 1'b0;
        #1;
        chk(data_oe === 1'b0, "R9 enable drops with strobes", 32'(data_oe), 32'd0);
        @(negedge clk);
        chk(wait_n === 1'b1 && data_oe === 1'b0 && mem_req === 1'b0,
            "R7 quiet after end", {29'd0, wait_n, data_oe, mem_req}, 32'd4);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(wait_n === 1'b1 && data_oe === 1'b0 && mem_req === 1'b0,
            "R1 reset outputs", {29'd0, wait_n, data_oe, mem_req}, 32'd4);
        rst = 1'b0;
        @(negedge clk);
        chk(wait_n === 1'b1 && data_oe === 1'b0, "R1 after reset",
            {30'd0, wait_n, data_oe}, 32'd2);

        // table of single reads, stretched reads and bursts (R2-R7, R9)
        for (int v = 0; v < NVEC; v++) begin
            do_read(VEC[v][31:16], int'(VEC[v][15:12]), int'(VEC[v][11:8]), VEC[v][7:4]);
        end

        // R8: two single reads with select held low
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = 16'h0A0A; burst = 1'b0;
        repeat (LAT + 1) @(negedge clk);
        chk(data_out === mword(16'h0A0A), "R8 first of pair", data_out, mword(16'h0A0A));
        rd_n = 1'b1;
        #1;
        chk(data_oe === 1'b0, "R9 enable off in gap", 32'(data_oe), 32'd0);
        @(negedge clk);
        chk(wait_n === 1'b1 && data_oe === 1'b0, "R8 gap state",
            {30'd0, wait_n, data_oe}, 32'd2);
        rd_n = 1'b0; addr = 16'h0B0C;
        #1;
        chk(mem_req === 1'b1 && mem_addr === 16'h0B0C, "R8 second request",
            32'(mem_addr), 32'h0B0C);
        @(negedge clk);
        chk(wait_n === 1'b0, "R8 wait again without select release", 32'(wait_n), 32'd0);
        repeat (LAT) @(negedge clk);
        chk(wait_n === 1'b1 && data_out === mword(16'h0B0C), "R8 second word",
            data_out, mword(16'h0B0C));
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);

        // R10: both strobes low together start nothing
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 16'h0C00;
        #1;
        chk(mem_req === 1'b0, "R10 no request on conflicting strobes", 32'(mem_req), 32'd0);
        @(negedge clk);
        chk(wait_n === 1'b1 && data_oe === 1'b0, "R10 no wait on conflicting strobes",
            {30'd0, wait_n, data_oe}, 32'd2);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);

        // R1: reset in the middle of a wait phase
        cs_n = 1'b0; rd_n = 1'b0; addr = 16'h0300;
        @(negedge clk);
        chk(wait_n === 1'b0, "R2 wait before mid reset", 32'(wait_n), 32'd0);
        rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        chk(wait_n === 1'b1 && data_oe === 1'b0, "R1 reset abandons read",
            {30'd0, wait_n, data_oe}, 32'd2);
        rst = 1'b0;
        repeat (LAT + 1) @(negedge clk);
        chk(wait_n === 1'b1 && data_oe === 1'b0 && mem_req === 1'b0, "R1 stays idle",
            {29'd0, wait_n, data_oe, mem_req}, 32'd4);

        do_read(16'h7777, 1, 0, 4'hF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule